// File: doc/BRIEF.md
# Inverted End-Around-Carry Modulo Adder

This block is a purely combinational adder for diminished-one modulo 2^n+1 arithmetic. It takes two n-bit words and returns their sum plus one, reduced modulo 2^n+1. The carry out of the top bit is inverted and fed back in as the carry into bit 0. It is meant as the closing adder of a modulo 2^n+1 multiplier, and it can also be used as a standalone modular adder.

Internally, a generate/propagate front end feeds a sparse prefix network. That network produces carries only at the boundaries of 4-bit groups, using the prefix operator (G,P)∘(G',P') = (G | P·G', P·P'). Each 4-bit conditional-sum block works out both of its possible sums ahead of time, and the group carry picks one of them.

The block has no clock, no state and no handshake. The output is valid as soon as the logic settles after an input change. For this reason the stream interface with valid/ready is not used.

Top module: `ieac_mod_adder`

## Requirements
- R1: For all n-bit inputs X and Y, out_sum equals ((X+Y+1) mod (2^n+1)) mod 2^n.
- R2: When X+Y equals 2^n-1, the true result 2^n is not representable, and out_sum is all zeros.
- R3: When X+Y is at least 2^n, the carry out of bit n-1 is discarded and no one is added, so out_sum equals X+Y-2^n.
- R4: When X+Y is below 2^n-1, the inverted carry adds one at bit 0, so out_sum equals X+Y+1.
- R5: A carry produced in one 4-bit group reaches every higher group boundary. For example, X=0x0FFE and Y=0x0001 give 0x1000.
- R6: Within each 4-bit group, the carry-in-1 candidate sum is exactly one more (mod 16) than the carry-in-0 candidate.
- R7: The block holds no state: out_sum reflects the current inputs within the same cycle, whatever the earlier inputs were.
- R8: The width parameter may be any multiple of 4, and other widths are rejected at elaboration. An 8-bit instance meets R1 for all 65,536 input pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_x | input | WIDTH | First addend |
| in_y | input | WIDTH | Second addend |
| out_sum | output | WIDTH | (in_x+in_y+1) mod (2^WIDTH+1), with 2^WIDTH shown as zero |

## Verification
The bench aims at the three regions of X+Y around 2^n:
- **Just below 2^n-1:** a design that forgot to invert the feedback carry would drop the added one here.
- **Exactly 2^n-1:** every bit propagates. A design whose carry loop is not broken would oscillate or give all ones instead of zero.
- **At or above 2^n:** a design that fed the raw carry back would add one too many.

Further patterns ripple a single carry across every group boundary. These catch a group carry taken from the wrong prefix span, or a conditional-sum block that selects the wrong candidate. An exhaustive sweep at 8 bits and random vectors at 16 bits cover the remaining space against an arithmetic reference.

// File: rtl/ieac_pkg.sv
package ieac_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Prefix operator: hi is the more significant span, lo the less significant.
  function automatic gp_t gp_join(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  localparam gp_t GP_IDENTITY = '{g: 1'b0, p: 1'b1};
endpackage

// File: rtl/ieac_gp_front.sv
module ieac_gp_front #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] bit_g,
  output logic [WIDTH-1:0] bit_p
);
  always_comb begin
    bit_g = op_a & op_b;
    bit_p = op_a ^ op_b;
  end

  // A bit cannot both generate and propagate (supports R1).
  always_comb begin
    p_gp_exclusive_r1: assert ((bit_g & bit_p) == '0)
      else $error("generate and propagate overlap");
  end
endmodule

// File: rtl/ieac_sparse_carry.sv
module ieac_sparse_carry
  import ieac_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SPAN  = 4
) (
  input  logic [WIDTH-1:0]        bit_g,
  input  logic [WIDTH-1:0]        bit_p,
  output logic [WIDTH/SPAN-1:0]   grp_cin
);
  localparam int NGRP = WIDTH / SPAN;

  gp_t grp_gp [NGRP];
  gp_t lo_pre [NGRP+1];
  gp_t hi_suf [NGRP+1];

  // Group (G,P) over each span of SPAN bits.
  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    always_comb begin
      gp_t acc;
      acc = GP_IDENTITY;
      for (int i = 0; i < SPAN; i++)
        acc = gp_join('{g: bit_g[k*SPAN+i], p: bit_p[k*SPAN+i]}, acc);
      grp_gp[k] = acc;
    end
  end

  // Sparse prefixes over the groups: lo_pre[k] spans groups below k,
  // hi_suf[k] spans groups k and above.
  always_comb begin
    lo_pre[0] = GP_IDENTITY;
    for (int k = 0; k < NGRP; k++)
      lo_pre[k+1] = gp_join(grp_gp[k], lo_pre[k]);
  end

  always_comb begin
    hi_suf[NGRP] = GP_IDENTITY;
    for (int k = NGRP - 1; k >= 0; k--)
      hi_suf[k] = gp_join(hi_suf[k+1], grp_gp[k]);
  end

  // Inverted end-around carry into each group boundary.
  for (genvar k = 0; k < NGRP; k++) begin : g_cin
    assign grp_cin[k] = lo_pre[k].g | (lo_pre[k].p & ~hi_suf[k].g);
  end

  // Neighbouring boundary carries obey the group ripple rule (R5).
  for (genvar k = 0; k + 1 < NGRP; k++) begin : g_chk
    always_comb begin
      p_ripple_consistent_r5: assert (grp_cin[k+1] ==
          (grp_gp[k].g | (grp_gp[k].p & grp_cin[k])))
        else $error("group carry %0d breaks ripple rule", k + 1);
    end
  end

  // Outside the all-propagate case, carry into bit 0 is the inverted carry out (R3).
  always_comb begin
    if (!hi_suf[0].p)
      p_wrap_inverted_r3: assert (grp_cin[0] ==
          ~(grp_gp[NGRP-1].g | (grp_gp[NGRP-1].p & grp_cin[NGRP-1])))
        else $error("end-around carry not inverted");
  end

  // All bits propagating forces every boundary carry to one (R2).
  always_comb begin
    if (hi_suf[0].p)
      p_allprop_carries_r2: assert (grp_cin == '1)
        else $error("all-propagate carries wrong");
  end
endmodule

// File: rtl/ieac_csum_nibble.sv
module ieac_csum_nibble #(
  parameter int SPAN = 4
) (
  input  logic [SPAN-1:0] nib_g,
  input  logic [SPAN-1:0] nib_p,
  input  logic            nib_cin,
  output logic [SPAN-1:0] nib_sum
);
  logic [SPAN-1:0] cand0, cand1;
  logic [SPAN:0]   rip0, rip1;

  always_comb begin
    rip0[0] = 1'b0;
    rip1[0] = 1'b1;
    for (int i = 0; i < SPAN; i++) begin
      rip0[i+1] = nib_g[i] | (nib_p[i] & rip0[i]);
      rip1[i+1] = nib_g[i] | (nib_p[i] & rip1[i]);
      cand0[i]  = nib_p[i] ^ rip0[i];
      cand1[i]  = nib_p[i] ^ rip1[i];
    end
  end

  assign nib_sum = nib_cin ? cand1 : cand0;

  // The carry-in-1 candidate is one above the carry-in-0 candidate (R6).
  always_comb begin
    p_candidates_step_r6: assert (cand1 == SPAN'(cand0 + 1'b1))
      else $error("candidate sums differ by %0d", cand1 - cand0);
  end
endmodule

// File: rtl/ieac_mod_adder.sv
module ieac_mod_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] in_x,
  input  logic [WIDTH-1:0] in_y,
  output logic [WIDTH-1:0] out_sum
);
  localparam int SPAN = 4;
  localparam int NGRP = WIDTH / SPAN;

  if (WIDTH % SPAN != 0 || WIDTH < SPAN) begin : g_bad_width
    $error("WIDTH must be a positive multiple of 4 (R8)");
  end

  logic [WIDTH-1:0] bit_g, bit_p;
  logic [NGRP-1:0]  grp_cin;

  ieac_gp_front #(.WIDTH(WIDTH)) u_front (
    .op_a  (in_x),
    .op_b  (in_y),
    .bit_g (bit_g),
    .bit_p (bit_p)
  );

  ieac_sparse_carry #(.WIDTH(WIDTH), .SPAN(SPAN)) u_carry (
    .bit_g   (bit_g),
    .bit_p   (bit_p),
    .grp_cin (grp_cin)
  );

  for (genvar k = 0; k < NGRP; k++) begin : g_nib
    ieac_csum_nibble #(.SPAN(SPAN)) u_nib (
      .nib_g   (bit_g[k*SPAN +: SPAN]),
      .nib_p   (bit_p[k*SPAN +: SPAN]),
      .nib_cin (grp_cin[k]),
      .nib_sum (out_sum[k*SPAN +: SPAN])
    );
  end

  // Arithmetic reference for the modular result (R1).
  localparam logic [WIDTH+1:0] MODV = (WIDTH+2)'(1) << WIDTH | (WIDTH+2)'(1);
  logic [WIDTH+1:0] ref_total, ref_red;
  always_comb begin
    ref_total = {2'b00, in_x} + {2'b00, in_y} + (WIDTH+2)'(1);
    ref_red   = (ref_total >= MODV) ? ref_total - MODV : ref_total;
    p_mod_result_r1: assert (out_sum == ref_red[WIDTH-1:0])
      else $error("modular sum mismatch");
  end
endmodule

// File: tb/ieac_mod_adder_bench.sv
module ieac_mod_adder_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [15:0] x16, y16, s16;
  logic [7:0]  x8, y8, s8;

  ieac_mod_adder #(.WIDTH(16)) u_ieac_mod_adder (
    .in_x (x16), .in_y (y16), .out_sum (s16));
  ieac_mod_adder #(.WIDTH(8)) u_narrow (
    .in_x (x8), .in_y (y8), .out_sum (s8));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int expect_mod(int a, int b, int w);
    int m;
    m = (1 << w) + 1;
    return ((a + b + 1) % m) & ((1 << w) - 1);
  endfunction

  task automatic apply16(input logic [15:0] a, input logic [15:0] b,
                         input string tag);
    int e;
    @(negedge clk);
    x16 = a; y16 = b;
    #1;
    e = expect_mod(int'(a), int'(b), 16);
    checks++;
    if (s16 !== 16'(e)) begin
      fails++;
      $display("FAIL %s: x=%h y=%h actual=%h expected=%h", tag, a, b, s16, 16'(e));
    end
  endtask

  task automatic t_zero_inputs;  // R4: 0+0+1
    apply16(16'h0000, 16'h0000, "R4 zero");
    apply16(16'h0FFF, 16'h0000, "R4 below");
    apply16(16'h7FFE, 16'h0000, "R4 near");
    apply16(16'hFFFD, 16'h0001, "R4 edge");
  endtask

  task automatic t_all_propagate;  // R2: X+Y = 2^n-1 gives 0
    apply16(16'hFFFF, 16'h0000, "R2 ones");
    apply16(16'h8000, 16'h7FFF, "R2 split");
    apply16(16'hA5A5, 16'h5A5A, "R2 alt");
  endtask

  task automatic t_carry_out;  // R3: X+Y >= 2^n
    apply16(16'hFFFF, 16'hFFFF, "R3 max");
    apply16(16'h8000, 16'h8000, "R3 exact");
    apply16(16'hFFFF, 16'h0002, "R3 wrap1");
    apply16(16'hF000, 16'h1000, "R3 top");
  endtask

  task automatic t_group_ripple;  // R5 and R6: carries across groups
    apply16(16'h000F, 16'h0001, "R5 g1");
    apply16(16'h0FFE, 16'h0001, "R5 g3");
    apply16(16'h00FF, 16'h0F00, "R6 sel");
    apply16(16'h1234, 16'h0DCB, "R6 mix");
  endtask

  task automatic t_no_state;  // R7: result tracks current inputs only
    apply16(16'hFFFF, 16'hFFFF, "R7 prev");
    apply16(16'h0001, 16'h0002, "R7 next");
    apply16(16'hFFFF, 16'h0000, "R7 prev2");
    apply16(16'h0003, 16'h0000, "R7 next2");
  endtask

  task automatic t_random16;  // R1: random vectors at 16 bits
    for (int i = 0; i < 2000; i++)
      apply16(16'($urandom), 16'($urandom), "R1 random");
  endtask

  task automatic t_exhaustive8;  // R8: every pair at 8 bits
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int e;
        @(negedge clk);
        x8 = 8'(a); y8 = 8'(b);
        #1;
        e = expect_mod(a, b, 8);
        checks++;
        if (s8 !== 8'(e)) begin
          fails++;
          $display("FAIL R8: x=%h y=%h actual=%h expected=%h", 8'(a), 8'(b), s8, 8'(e));
        end
      end
    end
  endtask

  initial begin
    x16 = '0; y16 = '0; x8 = '0; y8 = '0;
    t_zero_inputs();
    t_all_propagate();
    t_carry_out();
    t_group_ripple();
    t_no_state();
    t_random16();
    t_exhaustive8();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule